// File: doc/BRIEF.md
# MMU Access Permission Checker

This block sits after the TLB lookup and judges one memory access per clock. It takes the virtual address of the access, what kind of access it is (instruction fetch, data read or data write), its size, the processor's privilege mode, and the TLB result for it: the hit flag, the hit entry's two-bit protection field, its dirty bit and the way that hit. From these it decides whether the access may proceed or which exception it must raise.

There are three groups of checks. Address-error checks cover misalignment and user-mode accesses to the upper half of the address space. Protection checks decode the two-bit field, which grants different rights in privileged and user mode. The initial-page-write check fires on the first store to a clean page. Only one cause is reported per access, chosen in a fixed priority order. The verdict is registered: one cycle after the access it appears as a valid flag, a 12-bit event code, the offending address and the hit way.

Top module: `mmu_perm_check`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `excValid` is 0, whatever the access inputs are.
- R2: An access presented with `tlbHit` = 0 never raises an exception: `excValid` is 0 in the next cycle.
- R3: `accKind` is encoded 00 fetch, 01 read, 10 write, 11 treated as read. `accSize` is encoded 00 byte, 01 word, 10 longword, 11 treated as longword, and it is ignored for fetches. These are address errors: a fetch with `vaddr[0]` = 1, a word access with `vaddr[0]` = 1, and a longword access with `vaddr[1:0]` != 00. Byte accesses are never misaligned.
- R4: With `privMode` = 0 (user), any access with `vaddr[31]` = 1 is an address error.
- R5: Protection field rights: 00 lets privileged mode read only and gives user mode no access. 01 lets privileged mode read and write and gives user mode no access. 10 lets both modes read only. 11 lets both modes read and write. Fetches need the read right.
- R6: A protection violation reports code 0x0A0 for a fetch or read and 0x0C0 for a write.
- R7: A write that is otherwise allowed, to an entry whose dirty bit is 0, reports code 0x080 (initial page write).
- R8: Address errors report 0x0E0 for a fetch or read and 0x100 for a write. An address error takes priority over a protection violation, which takes priority over an initial page write. Exactly one code is reported.
- R9: The result appears exactly one cycle after the access. On an exception, `excAddr` equals the access's `vaddr` and `excWay` equals its `hitWay`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vaddr | input | 32 | Virtual address of the access |
| accKind | input | 2 | Access kind: fetch, read or write |
| accSize | input | 2 | Access size: byte, word or longword |
| privMode | input | 1 | 1 = privileged, 0 = user |
| tlbHit | input | 1 | The TLB lookup hit |
| protBits | input | 2 | Protection field of the hit entry |
| dirtyBit | input | 1 | Dirty bit of the hit entry |
| hitWay | input | 2 | Way of the hit entry |
| excValid | output | 1 | An exception is reported this cycle |
| excCode | output | 12 | Event code of the exception |
| excAddr | output | 32 | Address that caused the exception |
| excWay | output | 2 | Way that caused the exception |

## Verification
The bench sweeps every combination of access kind, size, low address bits, address bit 31, privilege mode, hit flag, protection field and dirty bit. That covers every alignment case against every access kind, and every protection setting in both modes. Because all the causes can be present at once, the sweep separates the priority order from the individual checks: one wrong priority shows up as a wrong code on the overlapping cases. The address's middle bits and the hit way change from access to access, so a stale or wrongly delayed address, or a wrong way, is caught.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RSVD  = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    SIZE_BYTE = 2'b00,
    SIZE_WORD = 2'b01,
    SIZE_LONG = 2'b10,
    SIZE_RSVD = 2'b11
  } accSize_e;

  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] CODE_PAGE_WR = 12'h080;
  localparam logic [CODE_W-1:0] CODE_PROT_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_PROT_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] CODE_ALGN_RD = 12'h0E0;
  localparam logic [CODE_W-1:0] CODE_ALGN_WR = 12'h100;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // a hit access is being judged
    logic addrErr;    // address error wins
    logic protErr;    // protection violation wins
    logic pageWrErr;  // initial page write wins
    logic isWrite;    // the access is a store
  } chkStrobe_t;

endpackage

// File: rtl/mmu_perm_ctrl.sv
module mmu_perm_ctrl
  import mmu_perm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addrLow,
  input  logic       addrTop,
  input  logic [1:0] accKind,
  input  logic [1:0] accSize,
  input  logic       privMode,
  input  logic       tlbHit,
  input  logic [1:0] protBits,
  input  logic       dirtyBit,
  output chkStrobe_t strb
);

  logic isWrite;
  logic isFetch;
  logic misAlign;
  logic userHigh;
  logic rawAddrErr;
  logic readOk;
  logic writeOk;
  logic rawProtErr;
  logic rawPageWr;

  always_comb begin
    isWrite = (accKind == KIND_WRITE);
    isFetch = (accKind == KIND_FETCH);

    if (isFetch) begin
      misAlign = addrLow[0];
    end else begin
      unique case (accSize)
        SIZE_BYTE: misAlign = 1'b0;
        SIZE_WORD: misAlign = addrLow[0];
        default:   misAlign = (addrLow != 2'b00);
      endcase
    end

    userHigh   = !privMode && addrTop;
    rawAddrErr = misAlign || userHigh;

    // protection field decode: bit1 = user may read, bit0 = writable
    readOk  = privMode || protBits[1];
    writeOk = privMode ? protBits[0] : (protBits == 2'b11);

    rawProtErr = isWrite ? !writeOk : !readOk;
    rawPageWr  = isWrite && !dirtyBit;
  end

  // fixed priority: address error, protection, initial page write
  always_comb begin
    strb.capture   = tlbHit;
    strb.isWrite   = isWrite;
    strb.addrErr   = tlbHit && rawAddrErr;
    strb.protErr   = tlbHit && !rawAddrErr && rawProtErr;
    strb.pageWrErr = tlbHit && !rawAddrErr && !rawProtErr && rawPageWr;
  end

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.addrErr, strb.protErr, strb.pageWrErr})); // R8

  AST_USER_HIGH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbHit && !privMode && addrTop) |-> strb.addrErr); // R4

  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbHit && privMode && accKind != KIND_FETCH && accSize == SIZE_BYTE)
      |-> !strb.addrErr); // R3

endmodule

// File: rtl/mmu_perm_dp.sv
module mmu_perm_dp
  import mmu_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chkStrobe_t        strb,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [WAY_W-1:0]  hitWay,
  output logic              excValid,
  output logic [CODE_W-1:0] excCode,
  output logic [ADDR_W-1:0] excAddr,
  output logic [WAY_W-1:0]  excWay
);

  logic              anyErr;
  logic [CODE_W-1:0] nextCode;

  always_comb begin
    anyErr = strb.addrErr || strb.protErr || strb.pageWrErr;
    if (strb.addrErr)      nextCode = strb.isWrite ? CODE_ALGN_WR : CODE_ALGN_RD;
    else if (strb.protErr) nextCode = strb.isWrite ? CODE_PROT_WR : CODE_PROT_RD;
    else                   nextCode = CODE_PAGE_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      excValid <= 1'b0;
      excCode  <= '0;
      excAddr  <= '0;
      excWay   <= '0;
    end else begin
      excValid <= anyErr;
      if (anyErr) begin
        excCode <= nextCode;
        excAddr <= vaddr;
        excWay  <= hitWay;
      end
    end
  end

  AST_NO_EXC_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> !excValid); // R2

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (excCode == CODE_PAGE_WR || excCode == CODE_PROT_RD ||
                  excCode == CODE_PROT_WR || excCode == CODE_ALGN_RD ||
                  excCode == CODE_ALGN_WR)); // R8

  AST_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.isWrite && (strb.protErr || strb.addrErr))
      |=> (excCode == CODE_PROT_WR || excCode == CODE_ALGN_WR)); // R6

  AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.addrErr || strb.protErr || strb.pageWrErr)
      |=> (excValid && excAddr == $past(vaddr) && excWay == $past(hitWay))); // R9

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accSize,
  input  logic              privMode,
  input  logic              tlbHit,
  input  logic [1:0]        protBits,
  input  logic              dirtyBit,
  input  logic [WAY_W-1:0]  hitWay,
  output logic              excValid,
  output logic [CODE_W-1:0] excCode,
  output logic [ADDR_W-1:0] excAddr,
  output logic [WAY_W-1:0]  excWay
);

  localparam int TOP_BIT = ADDR_W - 1;

  chkStrobe_t strb;

  mmu_perm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addrLow  (vaddr[1:0]),
    .addrTop  (vaddr[TOP_BIT]),
    .accKind  (accKind),
    .accSize  (accSize),
    .privMode (privMode),
    .tlbHit   (tlbHit),
    .protBits (protBits),
    .dirtyBit (dirtyBit),
    .strb     (strb)
  );

  mmu_perm_dp #(
    .ADDR_W (ADDR_W),
    .WAY_W  (WAY_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .vaddr    (vaddr),
    .hitWay   (hitWay),
    .excValid (excValid),
    .excCode  (excCode),
    .excAddr  (excAddr),
    .excWay   (excWay)
  );

endmodule

// File: tb/mmu_perm_check_bench.sv
`timescale 1ns/1ps
module mmu_perm_check_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  accKind = '0;
  logic [1:0]  accSize = '0;
  logic        privMode = 1'b0;
  logic        tlbHit = 1'b0;
  logic [1:0]  protBits = '0;
  logic        dirtyBit = 1'b0;
  logic [1:0]  hitWay = '0;
  logic        excValid;
  logic [11:0] excCode;
  logic [31:0] excAddr;
  logic [1:0]  excWay;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mmu_perm_check u_mmu_perm_check (
    .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .accKind(accKind),
    .accSize(accSize), .privMode(privMode), .tlbHit(tlbHit),
    .protBits(protBits), .dirtyBit(dirtyBit), .hitWay(hitWay),
    .excValid(excValid), .excCode(excCode), .excAddr(excAddr),
    .excWay(excWay)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (vaddr=%h kind=%0d size=%0d priv=%0d hit=%0d pr=%0d d=%0d)",
               tag, act, exp, vaddr, accKind, accSize, privMode, tlbHit,
               protBits, dirtyBit);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit        expV;
    logic [11:0] expC;
    string     tag;
    int        idx;
    // R1: an access that would fault is presented during reset
    vaddr = 32'h8000_0003; accKind = 2'b10; accSize = 2'b10; tlbHit = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 during reset", {31'd0, excValid}, 32'd0);
    rst_n = 1'b1;
    tlbHit = 1'b0;
    @(negedge clk);
    check("R1 first cycle", {31'd0, excValid}, 32'd0);

    idx = 0;
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 3; s++)
        for (int lo = 0; lo < 4; lo++)
          for (int hi = 0; hi < 2; hi++)
            for (int pm = 0; pm < 2; pm++)
              for (int h = 0; h < 2; h++)
                for (int pr = 0; pr < 4; pr++)
                  for (int d = 0; d < 2; d++) begin
                    bit isW, mis, ae, rdOk, wrOk, pv, ipw;
                    idx++;
                    accKind  = 2'(k);
                    accSize  = 2'(s);
                    vaddr    = {1'(hi), 31'(idx * 32'h0001_0104) & 31'h7FFF_FFFC} | 32'(lo);
                    privMode = 1'(pm);
                    tlbHit   = 1'(h);
                    protBits = 2'(pr);
                    dirtyBit = 1'(d);
                    hitWay   = 2'(idx);
                    // expected model from the requirements
                    isW = (k == 2);
                    if (k == 0)      mis = lo[0];          // R3 fetch
                    else if (s == 0) mis = 1'b0;           // R3 byte
                    else if (s == 1) mis = lo[0];          // R3 word
                    else             mis = (lo != 0);      // R3 longword
                    ae   = mis || (pm == 0 && hi == 1);    // R4
                    rdOk = (pm == 1) || pr[1];             // R5
                    wrOk = (pm == 1) ? pr[0] : (pr == 3);  // R5
                    pv   = isW ? !wrOk : !rdOk;
                    ipw  = isW && (d == 0);                // R7
                    expV = (h == 1) && (ae || pv || ipw);  // R2
                    if (ae) begin
                      expC = isW ? 12'h100 : 12'h0E0; tag = "R8/R3/R4 address error";
                    end else if (pv) begin
                      expC = isW ? 12'h0C0 : 12'h0A0; tag = "R6/R5 protection";
                    end else begin
                      expC = 12'h080; tag = "R7 page write";
                    end
                    @(posedge clk);
                    @(negedge clk);
                    check(h == 1 ? "R5/R3 valid flag" : "R2 miss quiet",
                          {31'd0, excValid}, {31'd0, expV});
                    if (expV && excValid) begin
                      check(tag, {20'd0, excCode}, {20'd0, expC});
                      check("R9 address", excAddr, vaddr);
                      check("R9 way", {30'd0, excWay}, {30'd0, hitWay});
                    end
                  end

    // R9: the result lasts one cycle only
    tlbHit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 one cycle", {31'd0, excValid}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule